// File: doc/BRIEF.md
# SYSREF Pulse Train Generator

This block turns a fast input clock into a low-rate alignment strobe. A two-stage pre-divide sets the interpolator rate. The first stage divides by a fixed 4 or 6, and the second stage is a prescaler of 1, 2 or 4. The block does not make a separate clock at that rate. It makes a one-cycle tick enable. Every later stage advances only on this tick.

An asynchronous request input passes through a two-flop synchronizer and is then re-timed onto the tick. A rising edge of the re-timed request starts the output. The output is a square wave with half-period `DIV` ticks, so its full period is 2 × `DIV` ticks. There are three output modes:
- Single mode gives one period.
- Burst mode gives a counted number of periods.
- Continuous mode repeats periods while the request stays high.

Configuration is written through a one-cycle write strobe into a pending register set. The pending set is copied to the active set only while the pulse engine is idle. A write made during a burst therefore waits until the burst ends. An illegal half-period value is clamped to a legal one and raises an error flag. A low sync enable holds the whole block idle.

Top module: `sysref_train_gen`

## Requirements
- R1: While `sync_en` is 0, `sysref_out` is 0 from the next clock edge, and requests are ignored. Dropping `sync_en` in the middle of a pulse forces the output low on the next edge.
- R2: Ticks occur every F × P input clocks. F is 4 when `cfg_fixed6`=0 and 6 when it is 1. P is 1, 2 or 4 for `cfg_pre` codes 0, 1 or 2. Code 3 also selects 4.
- R3: Each output period is high for `DIV` ticks and then low for `DIV` ticks, so it stays high for `DIV`×F×P clocks and repeats every 2×`DIV`×F×P clocks.
- R4: The request first passes two synchronizer flops. It is then sampled on ticks, and a rise is seen at the first tick that samples it high. The output goes high one tick later. Counted from the first clock after the request rises, this is F×P+3 to 2×F×P+2 clocks.
- R5: Mode code 0 (single) gives exactly one period per request rise. The reserved mode code 3 behaves the same way.
- R6: Mode code 1 (burst) gives `cfg_count` periods per request rise (0..15). A count of 0 gives no output.
- R7: Mode code 2 (continuous) repeats periods while the re-timed request is high. When the request falls, the output always completes its current full period and then stops low.
- R8: A write with a `DIV` value below 4 stores 4, and a value above 4098 stores 4098. An odd value inside that range stores the value minus 1. `div_err` goes to 1 after any such illegal write and to 0 after a legal write.
- R9: A configuration written while idle applies to the next request. A write made while pulses are in progress has no effect on them and applies to the following request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Sync-mode enable; 0 holds the block idle |
| req_in | input | 1 | Asynchronous output request |
| cfg_wr | input | 1 | One-cycle write strobe for the configuration fields |
| cfg_fixed6 | input | 1 | Fixed pre-divide select: 0 gives /4, 1 gives /6 |
| cfg_pre | input | 2 | Prescaler code: 0 gives /1, 1 gives /2, 2 or 3 give /4 |
| cfg_mode | input | 2 | Mode: 0 single, 1 burst, 2 continuous, 3 single |
| cfg_count | input | 4 | Burst period count |
| cfg_div | input | 13 | Half-period in ticks (`DIV`), even 4..4098 |
| sysref_out | output | 1 | Alignment strobe output |
| div_err | output | 1 | Last written `DIV` value was illegal |

## Verification
A wrong divide ratio or a stuck phase counter shows up in the first output pulse as a wrong high width. This is visible within one half-period, or at most `DIV`×F×P clocks after the output rises. A wrong remaining-pulse count or a wrong mode decode shows up as too many or too few rising edges before the output settles low. A wrong hand-off of configuration from pending to active shows up as a change of pulse width inside a burst. A broken request re-timing shows up as a start latency outside the window of one to two ticks.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  localparam int DIV_W   = 13;
  localparam int DIV_MIN = 4;
  localparam int DIV_MAX = 4098;
  localparam int CNT_W   = 4;
  localparam int TICK_W  = 5;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef struct packed {
    logic             fixed6;
    logic [1:0]       pre;
    mode_e            mode;
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] half;
  } cfg_t;

  function automatic logic div_illegal(input logic [DIV_W-1:0] d);
    return d[0] || (d < DIV_W'(DIV_MIN)) || (d > DIV_W'(DIV_MAX));
  endfunction

  function automatic logic [DIV_W-1:0] div_clamp(input logic [DIV_W-1:0] d);
    if (d < DIV_W'(DIV_MIN))      return DIV_W'(DIV_MIN);
    else if (d > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else                          return {d[DIV_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/sysref_tick_gen.sv
module sysref_tick_gen #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fixed6,
  input  logic [1:0] pre,
  output logic       tick
);
  logic [CNT_W-1:0] base, ratio, cnt;

  always_comb begin
    base = fixed6 ? CNT_W'(6) : CNT_W'(4);
    unique case (pre)
      2'd0:    ratio = base;
      2'd1:    ratio = base << 1;
      default: ratio = base << 2;
    endcase
    tick = en && (cnt >= ratio - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || tick)    cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end

  // R2: the smallest ratio is 4, so two ticks are never adjacent
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sysref_req_sync.sv
module sysref_req_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic req_async,
  output logic req_lvl,
  output logic req_rise
);
  logic s1, s2, rt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= req_async;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rt <= 1'b0;
    else if (!en)  rt <= 1'b0;
    else if (tick) rt <= s2;
  end

  assign req_lvl  = rt;
  assign req_rise = tick && s2 && !rt;

  // R4: the re-timed level only moves on a tick
  a_r4_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(req_lvl));
endmodule

// File: rtl/sysref_pulse_engine.sv
module sysref_pulse_engine
  import sysref_pkg::*;
#(
  parameter int HDIV_W = DIV_W,
  parameter int NCNT_W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              req_rise,
  input  logic              req_lvl,
  input  mode_e             mode,
  input  logic [NCNT_W-1:0] count,
  input  logic [HDIV_W-1:0] half,
  output logic              sysref,
  output logic              busy
);
  localparam int PH_W = HDIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} st_e;
  st_e              st;
  logic [PH_W-1:0]  ph, ph_nx, last;
  logic [NCNT_W-1:0] left;
  logic             more;

  always_comb begin
    ph_nx = ph + PH_W'(1);
    last  = {half, 1'b0} - PH_W'(1);
    more  = (mode == MODE_CONT) ? req_lvl : (left != NCNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; left <= '0; sysref <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE; ph <= '0; left <= '0; sysref <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_rise) begin
          unique case (mode)
            MODE_BURST: if (count != '0) begin st <= S_ARM; left <= count; end
            default:    begin st <= S_ARM; left <= NCNT_W'(1); end
          endcase
        end
        S_ARM: if (tick) begin
          st <= S_RUN; ph <= '0; sysref <= 1'b1;
        end
        S_RUN: if (tick) begin
          if (ph == last) begin
            if (more) begin
              ph <= '0; sysref <= 1'b1;
              if (mode != MODE_CONT) left <= left - NCNT_W'(1);
            end else begin
              st <= S_IDLE; sysref <= 1'b0;
            end
          end else begin
            ph     <= ph_nx;
            sysref <= (ph_nx < {1'b0, half});
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);

  // R1: disabled block drives low
  a_r1_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sysref);
  // R3: output edges fall only on ticks
  a_r3_edges_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(sysref));
  // R5: an idle engine keeps the output low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sysref);
endmodule

// File: rtl/sysref_train_gen.sv
module sysref_train_gen
  import sysref_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic             req_in,
  input  logic             cfg_wr,
  input  logic             cfg_fixed6,
  input  logic [1:0]       cfg_pre,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             sysref_out,
  output logic             div_err
);
  localparam cfg_t CFG_RST = '{fixed6: 1'b0, pre: 2'd0, mode: MODE_SINGLE,
                               count: CNT_W'(1), half: DIV_W'(DIV_MIN)};

  cfg_t pend, act;
  logic tick, req_lvl, req_rise, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= CFG_RST;
      div_err <= 1'b0;
    end else if (cfg_wr) begin
      pend.fixed6 <= cfg_fixed6;
      pend.pre    <= cfg_pre;
      pend.mode   <= mode_e'(cfg_mode);
      pend.count  <= cfg_count;
      pend.half   <= div_clamp(cfg_div);
      div_err     <= div_illegal(cfg_div);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act <= CFG_RST;
    else if (!busy) act <= pend;
  end

  sysref_tick_gen #(.CNT_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(sync_en),
    .fixed6(act.fixed6), .pre(act.pre), .tick(tick)
  );

  sysref_req_sync u_req (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .tick(tick),
    .req_async(req_in), .req_lvl(req_lvl), .req_rise(req_rise)
  );

  sysref_pulse_engine #(.HDIV_W(DIV_W), .NCNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(sync_en), .tick(tick),
    .req_rise(req_rise), .req_lvl(req_lvl), .mode(act.mode),
    .count(act.count), .half(act.half), .sysref(sysref_out), .busy(busy)
  );

  // R8: the active half-period is always even and in range
  a_r8_active_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !act.half[0] && act.half >= DIV_W'(DIV_MIN) && act.half <= DIV_W'(DIV_MAX));
  // R9: configuration stays frozen while pulses are in flight
  a_r9_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act));
endmodule

// File: tb/test_sysref_train_gen.sv
module test_sysref_train_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic        clk = 1'b0, rst_n = 1'b0, sync_en = 1'b0, req_in = 1'b0;
  logic        cfg_wr = 1'b0, cfg_fixed6 = 1'b0;
  logic [1:0]  cfg_pre = '0, cfg_mode = '0;
  logic [3:0]  cfg_count = '0;
  logic [12:0] cfg_div = '0;
  logic        sysref_out, div_err;

  int checks = 0, failures = 0;
  int m_rises, m_minw, m_maxw, m_minp, m_maxp, m_lat;
  logic m_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysref_train_gen i_sysref_train_gen (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .req_in(req_in),
    .cfg_wr(cfg_wr), .cfg_fixed6(cfg_fixed6), .cfg_pre(cfg_pre),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_div(cfg_div),
    .sysref_out(sysref_out), .div_err(div_err)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic write_cfg(input bit f6, input logic [1:0] pre, input logic [1:0] mode,
                           input logic [3:0] cnt, input logic [12:0] dv);
    @(negedge clk);
    cfg_fixed6 = f6; cfg_pre = pre; cfg_mode = mode; cfg_count = cnt; cfg_div = dv;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // raise the request, hold it, sample the output each negedge;
  // optionally rewrite cfg_div at cycle wr_at
  task automatic run(input int hold, input int window, input int wr_at, input logic [12:0] wr_div);
    int hi_run, last_rise;
    logic prev;
    m_rises = 0; m_minw = 1 << 30; m_maxw = 0; m_minp = 1 << 30; m_maxp = 0;
    m_lat = -1; hi_run = 0; last_rise = -1; prev = 1'b0;
    @(negedge clk);
    req_in = 1'b1;
    for (int i = 1; i <= window; i++) begin
      @(negedge clk);
      if (sysref_out && !prev) begin
        m_rises++;
        if (m_lat < 0) m_lat = i;
        if (last_rise >= 0) begin
          if (i - last_rise < m_minp) m_minp = i - last_rise;
          if (i - last_rise > m_maxp) m_maxp = i - last_rise;
        end
        last_rise = i;
      end
      if (sysref_out) hi_run++;
      else if (prev) begin
        if (hi_run < m_minw) m_minw = hi_run;
        if (hi_run > m_maxw) m_maxw = hi_run;
        hi_run = 0;
      end
      prev = sysref_out;
      req_in = (i < hold);
      if (i == wr_at) begin cfg_div = wr_div; cfg_wr = 1'b1; end
      else cfg_wr = 1'b0;
    end
    req_in = 1'b0; cfg_wr = 1'b0;
    m_end = sysref_out;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(sysref_out == 1'b0, "R1 reset out", int'(sysref_out), 0);
    check(div_err == 1'b0, "R8 reset err", int'(div_err), 0);
  endtask

  task automatic t_disabled;
    sync_en = 1'b0;
    run(60, 200, -1, '0);
    check(m_rises == 0, "R1 disabled pulses", m_rises, 0);
    sync_en = 1'b1;
  endtask

  task automatic t_single;
    write_cfg(1'b0, 2'd0, 2'd0, 4'd9, 13'd4);
    run(60, 300, -1, '0);
    check(m_rises == 1, "R5 single count", m_rises, 1);
    check(m_minw == 16 && m_maxw == 16, "R3 single width", m_minw, 16);
    check(m_lat >= 7 && m_lat <= 10, "R4 start latency", m_lat, 7);
    check(m_end == 1'b0, "R5 ends low", int'(m_end), 0);
  endtask

  task automatic t_burst3;
    write_cfg(1'b0, 2'd1, 2'd1, 4'd3, 13'd6);
    run(60, 600, -1, '0);
    check(m_rises == 3, "R6 burst count", m_rises, 3);
    check(m_minw == 48 && m_maxw == 48, "R2 width ratio8", m_maxw, 48);
    check(m_minp == 96 && m_maxp == 96, "R3 period", m_minp, 96);
  endtask

  task automatic t_burst_edges;
    write_cfg(1'b0, 2'd0, 2'd1, 4'd0, 13'd4);
    run(60, 300, -1, '0);
    check(m_rises == 0, "R6 zero count", m_rises, 0);
    write_cfg(1'b0, 2'd0, 2'd1, 4'd15, 13'd4);
    run(60, 700, -1, '0);
    check(m_rises == 15, "R6 fifteen count", m_rises, 15);
  endtask

  task automatic t_ratio24;
    write_cfg(1'b1, 2'd3, 2'd3, 4'd5, 13'd4);
    run(60, 700, -1, '0);
    check(m_rises == 1, "R5 mode3 single", m_rises, 1);
    check(m_minw == 96 && m_maxw == 96, "R2 width ratio24", m_maxw, 96);
  endtask

  task automatic t_cont;
    write_cfg(1'b0, 2'd0, 2'd2, 4'd1, 13'd4);
    run(150, 400, -1, '0);
    check(m_rises >= 4 && m_rises <= 6, "R7 cont pulses", m_rises, 5);
    check(m_minw == 16 && m_maxw == 16, "R7 full periods", m_minw, 16);
    check(m_end == 1'b0, "R7 stops low", int'(m_end), 0);
  endtask

  task automatic t_clamp;
    write_cfg(1'b0, 2'd0, 2'd0, 4'd1, 13'd7);
    check(div_err == 1'b1, "R8 odd err", int'(div_err), 1);
    run(60, 300, -1, '0);
    check(m_maxw == 24 && m_minw == 24, "R8 odd clamp", m_maxw, 24);
    write_cfg(1'b0, 2'd0, 2'd0, 4'd1, 13'd2);
    check(div_err == 1'b1, "R8 low err", int'(div_err), 1);
    run(60, 300, -1, '0);
    check(m_maxw == 16, "R8 low clamp", m_maxw, 16);
    write_cfg(1'b0, 2'd0, 2'd0, 4'd1, 13'd5000);
    run(60, 33000, -1, '0);
    check(m_maxw == 16392, "R8 high clamp", m_maxw, 16392);
    write_cfg(1'b0, 2'd0, 2'd0, 4'd1, 13'd8);
    check(div_err == 1'b0, "R8 legal clears", int'(div_err), 0);
  endtask

  task automatic t_held;
    write_cfg(1'b0, 2'd0, 2'd1, 4'd4, 13'd4);
    run(60, 400, 50, 13'd8);
    check(m_rises == 4, "R9 burst count", m_rises, 4);
    check(m_minw == 16 && m_maxw == 16, "R9 held width", m_maxw, 16);
    run(60, 600, -1, '0);
    check(m_minw == 32 && m_maxw == 32, "R9 next request", m_minw, 32);
  endtask

  task automatic t_drop_en;
    write_cfg(1'b0, 2'd0, 2'd0, 4'd1, 13'd20);
    @(negedge clk); req_in = 1'b1;
    repeat (30) @(negedge clk);
    check(sysref_out == 1'b1, "R1 mid pulse high", int'(sysref_out), 1);
    sync_en = 1'b0;
    @(negedge clk);
    check(sysref_out == 1'b0, "R1 drop forces low", int'(sysref_out), 0);
    req_in = 1'b0; sync_en = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_single();
        t_burst3();
        t_burst_edges();
        t_ratio24();
        t_cont();
        t_clamp();
        t_held();
        t_drop_en();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule